// File: doc/BRIEF.md
# Page-Mode DRAM Access Sequencer

This block turns host access requests into the row and column strobe sequence of an asynchronous DRAM array that is split into banks. The host presents an address, a bank number and a chip select, then pulses a strobe. The sequencer captures the request, drives the row half and then the column half of the address on a shared DRAM address bus, and strobes the row (one RAS line per bank) and then the column (one shared CAS line). An active-low acknowledge tells the host when the data phase may complete.

After an access the row is left open. The next request is compared against the open bank and row. A match needs only a column strobe, so it is short. A mismatch closes the row, waits out a fixed precharge time and reopens the row. A refresh engine outside the block asks for the array through a request and grant pair. While the grant is held, the sequencer keeps every RAS line released and forgets the open row. A host request that arrives during a refresh is kept and served once the refresh ends.

After reset the sequencer ignores all memory traffic until the host writes to a configuration address once.

Top module: `pgdram_seq`

## Requirements
- R1: After reset, every `ras_n` line is high, `cas_n` and `ack_n` are high and `rfsh_gnt` is low. Until the block is armed, only one request has any effect: a strobe with `cs` and `wr` high and `addr == CFG_ADDR`. That request arms the block and pulls `ack_n` low after the edge where the strobe is sampled (edge E0), for one clock, with no RAS or CAS activity.
- R2: A strobe is ignored when it arrives before arming (other than the configuration write) or when `cs` is low. In that case no RAS line falls and `ack_n` stays high.
- R3: An opening access starts when no row is open. E0 is the edge where the strobe is sampled. The selected bank's `ras_n` falls at E0, `cas_n` falls at E1, `ack_n` falls at E2, and both rise at E3. The access takes four clocks.
- R4: `ack_n` is low for exactly one clock on every access. `cas_n` rises on the same edge where `ack_n` rises. The RAS line stays low after the access ends.
- R5: A page hit is a request whose bank and row match the open ones. On a hit, `cas_n` falls at E0 with the new column already on `ma`, `ack_n` falls at E1, and the access ends at E2, three clocks in all.
- R6: A page miss is a request made while a row is open that differs in bank or row. On a miss, all `ras_n` lines are high from E0 for `PRE_CYC` clocks. The new row then opens at E0+`PRE_CYC`, and the access follows the timing of R3 from that edge.
- R7: The row is `addr[ADDR_W-1:COL_W]` and the column is `addr[COL_W-1:0]`, so one page holds 2^`COL_W` columns. A different bank number counts as a miss even when the row is equal.
- R8: `ma` carries the zero-extended row from the edge where RAS falls, and switches to the zero-extended column one edge later.
- R9: When `rfsh_req` is high while the sequencer is idle, `rfsh_gnt` rises at the next edge and every `ras_n` is high while `rfsh_gnt` is high. `rfsh_gnt` falls at the edge after `rfsh_req` falls. The open row is forgotten, so the next request is an opening access.
- R10: A strobe accepted while `rfsh_gnt` is high is held. Its RAS falls at the edge where `rfsh_gnt` falls, and its `ack_n` falls two edges later.
- R11: At most one `ras_n` line is low at any time, and `cas_n` is low only while some `ras_n` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| strobe | input | 1 | Host request, sampled high for one clock |
| wr | input | 1 | Host write flag, used for the configuration write |
| cs | input | 1 | Chip select for this array |
| bank | input | BANK_W | Bank number of the request |
| addr | input | ADDR_W | Host address: row in upper bits, column in lower bits |
| rfsh_req | input | 1 | Refresh engine asks for the array |
| rfsh_gnt | output | 1 | Array handed to the refresh engine |
| ma | output | MA_W | Multiplexed DRAM address (row, then column) |
| ras_n | output | NBANK | Row strobe per bank, active low |
| cas_n | output | 1 | Column strobe, active low |
| ack_n | output | 1 | Transfer acknowledge to the host, active low |

## Verification
The bench builds the sequencer with a 16-bit address, a 6-bit column field (a 64-column page and a 10-bit row), two banks, a three-clock precharge and the configuration address 0xFFF0. With a page this small, neighbouring host addresses such as 0x017F and 0x0180 fall in different rows, so hits and misses on both sides of a row boundary, and misses caused by the bank alone, come up within a few vectors. After arming, the same 0xFFF0 address is reused as an ordinary access to row 0x3FF. This shows that the configuration decode stops mattering once the block is armed.

// File: rtl/pgseq_pkg.sv
package pgseq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ACT,
        ST_COL,
        ST_ACK,
        ST_PRE,
        ST_REF,
        ST_CFG
    } seq_state_e;

endpackage

// File: rtl/pgseq_split.sv
module pgseq_split #(
    parameter int ADDR_W = 24,
    parameter int COL_W  = 12,
    localparam int ROW_W = ADDR_W - COL_W,
    localparam int MA_W  = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  logic [ADDR_W-1:0] addr_q,
    input  logic              mux_col,
    output logic [MA_W-1:0]   ma
);

    logic [ROW_W-1:0] row;
    logic [COL_W-1:0] col;

    assign row = addr_q[ADDR_W-1:COL_W];
    assign col = addr_q[COL_W-1:0];

    always_comb begin
        if (mux_col) ma = MA_W'(col);
        else         ma = MA_W'(row);
    end

endmodule

// File: rtl/pgseq_pagecmp.sv
module pgseq_pagecmp #(
    parameter int ROW_W  = 12,
    parameter int BANK_W = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              clear,
    input  logic [BANK_W-1:0] ld_bank,
    input  logic [ROW_W-1:0]  ld_row,
    input  logic [BANK_W-1:0] cmp_bank,
    input  logic [ROW_W-1:0]  cmp_row,
    output logic              hit
);

    typedef struct packed {
        logic              vld;
        logic [BANK_W-1:0] bank;
        logic [ROW_W-1:0]  row;
    } page_t;

    page_t pg_d, pg_q;

    always_comb begin
        pg_d = pg_q;
        if (clear) begin
            pg_d.vld = 1'b0;
        end else if (load) begin
            pg_d.vld  = 1'b1;
            pg_d.bank = ld_bank;
            pg_d.row  = ld_row;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pg_q <= '0;
        else        pg_q <= pg_d;
    end

    assign hit = pg_q.vld && (pg_q.bank == cmp_bank) && (pg_q.row == cmp_row);

endmodule

// File: rtl/pgseq_fsm.sv
module pgseq_fsm
    import pgseq_pkg::*;
#(
    parameter int              ADDR_W   = 24,
    parameter int              BANK_W   = 1,
    parameter int              PRE_CYC  = 3,
    parameter logic [ADDR_W-1:0] CFG_ADDR = '1,
    localparam int             CNT_W    = (PRE_CYC > 1) ? $clog2(PRE_CYC) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe,
    input  logic              wr,
    input  logic              cs,
    input  logic [BANK_W-1:0] bank,
    input  logic [ADDR_W-1:0] addr,
    input  logic              pg_hit,
    input  logic              rfsh_req,
    output logic [ADDR_W-1:0] addr_q,
    output logic [BANK_W-1:0] bank_q,
    output logic              ras_on,
    output logic              mux_col,
    output logic              cas_n,
    output logic              ack_n,
    output logic              rfsh_gnt,
    output logic              pg_load,
    output logic              pg_clear
);

    typedef struct packed {
        seq_state_e        state;
        logic [CNT_W-1:0]  cnt;
        logic              armed;
        logic              pend;
        logic [ADDR_W-1:0] addr;
        logic [BANK_W-1:0] bank;
        logic              ras_on;
        logic              mux_col;
        logic              cas_n;
        logic              ack_n;
        logic              gnt;
    } fsm_t;

    localparam fsm_t FSM_RST = '{
        state:   ST_IDLE,
        cnt:     '0,
        armed:   1'b0,
        pend:    1'b0,
        addr:    '0,
        bank:    '0,
        ras_on:  1'b0,
        mux_col: 1'b0,
        cas_n:   1'b1,
        ack_n:   1'b1,
        gnt:     1'b0
    };

    fsm_t s_d, s_q;
    logic accept;

    assign accept = strobe && cs;

    always_comb begin
        s_d      = s_q;
        pg_load  = 1'b0;
        pg_clear = 1'b0;
        unique case (s_q.state)
            ST_IDLE: begin
                if (rfsh_req) begin
                    // refresh wins over a request arriving on the same edge
                    s_d.state  = ST_REF;
                    s_d.ras_on = 1'b0;
                    s_d.gnt    = 1'b1;
                    pg_clear   = 1'b1;
                    if (accept && s_q.armed) begin
                        s_d.pend = 1'b1;
                        s_d.addr = addr;
                        s_d.bank = bank;
                    end
                end else if (accept) begin
                    if (!s_q.armed) begin
                        if (wr && (addr == CFG_ADDR)) begin
                            s_d.armed = 1'b1;
                            s_d.ack_n = 1'b0;
                            s_d.state = ST_CFG;
                        end
                    end else begin
                        s_d.addr = addr;
                        s_d.bank = bank;
                        if (s_q.ras_on && pg_hit) begin
                            s_d.mux_col = 1'b1;
                            s_d.cas_n   = 1'b0;
                            s_d.state   = ST_COL;
                        end else if (s_q.ras_on) begin
                            s_d.ras_on = 1'b0;
                            s_d.cnt    = CNT_W'(PRE_CYC - 1);
                            s_d.state  = ST_PRE;
                            pg_clear   = 1'b1;
                        end else begin
                            s_d.ras_on  = 1'b1;
                            s_d.mux_col = 1'b0;
                            s_d.state   = ST_ACT;
                        end
                    end
                end
            end
            ST_ACT: begin
                pg_load     = 1'b1;
                s_d.mux_col = 1'b1;
                s_d.cas_n   = 1'b0;
                s_d.state   = ST_COL;
            end
            ST_COL: begin
                s_d.ack_n = 1'b0;
                s_d.state = ST_ACK;
            end
            ST_ACK: begin
                s_d.ack_n = 1'b1;
                s_d.cas_n = 1'b1;
                s_d.state = ST_IDLE;
            end
            ST_PRE: begin
                if (s_q.cnt == '0) begin
                    s_d.ras_on  = 1'b1;
                    s_d.mux_col = 1'b0;
                    s_d.state   = ST_ACT;
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            ST_REF: begin
                if (accept && s_q.armed && !s_q.pend) begin
                    s_d.pend = 1'b1;
                    s_d.addr = addr;
                    s_d.bank = bank;
                end
                if (!rfsh_req) begin
                    s_d.gnt = 1'b0;
                    if (s_d.pend) begin
                        s_d.pend    = 1'b0;
                        s_d.ras_on  = 1'b1;
                        s_d.mux_col = 1'b0;
                        s_d.state   = ST_ACT;
                    end else begin
                        s_d.state = ST_IDLE;
                    end
                end
            end
            ST_CFG: begin
                s_d.ack_n = 1'b1;
                s_d.state = ST_IDLE;
            end
            default: s_d = FSM_RST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= FSM_RST;
        else        s_q <= s_d;
    end

    assign addr_q   = s_q.addr;
    assign bank_q   = s_q.bank;
    assign ras_on   = s_q.ras_on;
    assign mux_col  = s_q.mux_col;
    assign cas_n    = s_q.cas_n;
    assign ack_n    = s_q.ack_n;
    assign rfsh_gnt = s_q.gnt;

endmodule

// File: rtl/pgdram_seq.sv
module pgdram_seq #(
    parameter int                ADDR_W   = 24,
    parameter int                COL_W    = 12,
    parameter int                NBANK    = 2,
    parameter int                PRE_CYC  = 3,
    parameter logic [ADDR_W-1:0] CFG_ADDR = '1,
    localparam int               ROW_W    = ADDR_W - COL_W,
    localparam int               MA_W     = (ROW_W > COL_W) ? ROW_W : COL_W,
    localparam int               BANK_W   = (NBANK > 1) ? $clog2(NBANK) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe,
    input  logic              wr,
    input  logic              cs,
    input  logic [BANK_W-1:0] bank,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rfsh_req,
    output logic              rfsh_gnt,
    output logic [MA_W-1:0]   ma,
    output logic [NBANK-1:0]  ras_n,
    output logic              cas_n,
    output logic              ack_n
);

    logic [ADDR_W-1:0] addr_q;
    logic [BANK_W-1:0] bank_q;
    logic              ras_on;
    logic              mux_col;
    logic              pg_hit;
    logic              pg_load;
    logic              pg_clear;

    pgseq_fsm #(
        .ADDR_W   (ADDR_W),
        .BANK_W   (BANK_W),
        .PRE_CYC  (PRE_CYC),
        .CFG_ADDR (CFG_ADDR)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe   (strobe),
        .wr       (wr),
        .cs       (cs),
        .bank     (bank),
        .addr     (addr),
        .pg_hit   (pg_hit),
        .rfsh_req (rfsh_req),
        .addr_q   (addr_q),
        .bank_q   (bank_q),
        .ras_on   (ras_on),
        .mux_col  (mux_col),
        .cas_n    (cas_n),
        .ack_n    (ack_n),
        .rfsh_gnt (rfsh_gnt),
        .pg_load  (pg_load),
        .pg_clear (pg_clear)
    );

    pgseq_pagecmp #(
        .ROW_W  (ROW_W),
        .BANK_W (BANK_W)
    ) u_pagecmp (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (pg_load),
        .clear    (pg_clear),
        .ld_bank  (bank_q),
        .ld_row   (addr_q[ADDR_W-1:COL_W]),
        .cmp_bank (bank),
        .cmp_row  (addr[ADDR_W-1:COL_W]),
        .hit      (pg_hit)
    );

    pgseq_split #(
        .ADDR_W (ADDR_W),
        .COL_W  (COL_W)
    ) u_split (
        .addr_q  (addr_q),
        .mux_col (mux_col),
        .ma      (ma)
    );

    for (genvar gi = 0; gi < NBANK; gi++) begin : g_ras
        assign ras_n[gi] = !(ras_on && (bank_q == BANK_W'(gi)));
    end

endmodule

// File: rtl/pgseq_chk.sv
module pgseq_chk #(
    parameter int NBANK = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NBANK-1:0] ras_n,
    input logic             cas_n,
    input logic             ack_n,
    input logic             rfsh_gnt
);

    // R4
    ack_single_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_n |=> ack_n);

    // R4
    cas_ends_with_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack_n && !cas_n) |=> cas_n);

    // R4
    row_kept_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack_n && !cas_n) |=> (ras_n == $past(ras_n)));

    // R11
    single_row_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~ras_n) <= 1);

    // R11
    cas_under_ras_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cas_n |-> !(&ras_n));

    // R9
    grant_rows_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rfsh_gnt |-> (&ras_n));

endmodule

bind pgdram_seq pgseq_chk #(.NBANK(NBANK)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ras_n    (ras_n),
    .cas_n    (cas_n),
    .ack_n    (ack_n),
    .rfsh_gnt (rfsh_gnt)
);

// File: tb/tb_pgdram_seq.sv
module tb_pgdram_seq;

    localparam int              ADDR_W = 16;
    localparam int              COL_W  = 6;
    localparam int              MA_W   = 10;
    localparam logic [15:0]     CFG    = 16'hFFF0;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             strobe = 1'b0;
    logic             wr = 1'b0;
    logic             cs = 1'b0;
    logic [0:0]       bank = 1'b0;
    logic [15:0]      addr = '0;
    logic             rfsh_req = 1'b0;
    logic             rfsh_gnt;
    logic [MA_W-1:0]  ma;
    logic [1:0]       ras_n;
    logic             cas_n;
    logic             ack_n;

    int tests = 0;
    int fails = 0;

    always #5 clk = ~clk;

    pgdram_seq #(
        .ADDR_W   (ADDR_W),
        .COL_W    (COL_W),
        .NBANK    (2),
        .PRE_CYC  (3),
        .CFG_ADDR (CFG)
    ) dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe   (strobe),
        .wr       (wr),
        .cs       (cs),
        .bank     (bank),
        .addr     (addr),
        .rfsh_req (rfsh_req),
        .rfsh_gnt (rfsh_gnt),
        .ma       (ma),
        .ras_n    (ras_n),
        .cas_n    (cas_n),
        .ack_n    (ack_n)
    );

    // address, bank, expected acknowledge edge counted from E0
    localparam logic [20:0] VECS [0:7] = '{
        {16'h0140, 1'b0, 4'd2},   // opening, row 5
        {16'h017F, 1'b0, 4'd1},   // hit, last column of row 5
        {16'h0180, 1'b0, 4'd5},   // miss, row 6
        {16'h01A5, 1'b0, 4'd1},   // hit
        {16'h01A5, 1'b1, 4'd5},   // miss by bank only
        {16'h0190, 1'b1, 4'd1},   // hit
        {16'hFFF0, 1'b1, 4'd5},   // config address now plain, row 0x3FF
        {16'hFFC0, 1'b1, 4'd1}    // hit
    };

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [MA_W-1:0] col_of(input logic [15:0] a);
        return MA_W'(a[COL_W-1:0]);
    endfunction

    function automatic logic [MA_W-1:0] row_of(input logic [15:0] a);
        return MA_W'(a[15:COL_W]);
    endfunction

    task automatic pulse(input logic [15:0] a, input logic b, input logic w,
                         input logic c);
        @(negedge clk);
        strobe = 1'b1; cs = c; wr = w; addr = a; bank = b;
        @(posedge clk);
        @(negedge clk);
        strobe = 1'b0;
    endtask

    // returns at the negedge where ack_n is low; k = edges after E0
    task automatic access(input logic [15:0] a, input logic b, input logic w,
                          output int k);
        pulse(a, b, w, 1'b1);
        k = 0;
        while (ack_n && k < 12) begin
            @(negedge clk);
            k++;
        end
    endtask

    task automatic quiet_window(input string req, input int n);
        bit ack_seen = 0;
        bit ras_seen = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (!ack_n) ack_seen = 1;
            if (ras_n != 2'b11) ras_seen = 1;
        end
        check(!ack_seen, req, 32'(ack_seen), 0);
        check(!ras_seen, req, 32'(ras_seen), 0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin : main
        int k;
        logic [1:0] ras_keep;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(ras_n == 2'b11, "R1 ras_n", 32'(ras_n), 32'h3);
        check(cas_n && ack_n, "R1 cas/ack", {cas_n, ack_n}, 32'h3);
        check(!rfsh_gnt, "R1 gnt", 32'(rfsh_gnt), 0);

        // R2 access before arming is ignored
        pulse(16'h0140, 1'b0, 1'b0, 1'b1);
        quiet_window("R2 unarmed", 6);
        // R1 write to a non-config address does not arm
        pulse(16'h0140, 1'b0, 1'b1, 1'b1);
        quiet_window("R1 wrong cfg", 6);

        // R1 configuration write
        access(CFG, 1'b0, 1'b1, k);
        check(k == 0, "R1 cfg ack edge", 32'(k), 0);
        check(ras_n == 2'b11 && cas_n, "R1 cfg no strobes", {ras_n, cas_n}, 32'h7);
        @(negedge clk);
        check(ack_n, "R1 cfg ack one clk", 32'(ack_n), 1);

        // R2 chip select low is ignored
        pulse(16'h0140, 1'b0, 1'b0, 1'b0);
        quiet_window("R2 cs low", 6);

        // R3 R5 R6 R7 R8 R4 vector walk
        for (int v = 0; v < 8; v++) begin
            logic [15:0] a;
            logic        b;
            int          lat;
            a   = VECS[v][20:5];
            b   = VECS[v][4];
            lat = int'(VECS[v][3:0]);
            access(a, b, 1'b0, k);
            check(k == lat, "R3/R5/R6/R7 ack latency", 32'(k), 32'(lat));
            check(ras_n == ~(2'b01 << b), "R7 bank ras", 32'(ras_n),
                  32'(~(2'b01 << b)));
            check(ma == col_of(a), "R8 column on ma", 32'(ma), 32'(col_of(a)));
            check(!cas_n, "R3 cas with ack", 32'(cas_n), 0);
            ras_keep = ras_n;
            @(negedge clk);
            check(ack_n && cas_n, "R4 release", {ack_n, cas_n}, 32'h3);
            check(ras_n == ras_keep, "R4 row stays open", 32'(ras_n), 32'(ras_keep));
        end

        // R6 R8 precharge window on a miss, row then column on ma
        pulse(16'h0203, 1'b0, 1'b0, 1'b1);
        for (int e = 0; e < 3; e++) begin
            check(ras_n == 2'b11, "R6 precharge", 32'(ras_n), 32'h3);
            @(negedge clk);
        end
        check(ras_n == 2'b10, "R6 reopen", 32'(ras_n), 32'h2);
        check(ma == row_of(16'h0203), "R8 row on ma", 32'(ma), 32'(row_of(16'h0203)));
        @(negedge clk);
        check(ma == col_of(16'h0203), "R8 column switch", 32'(ma),
              32'(col_of(16'h0203)));
        check(!cas_n && ack_n, "R3 cas before ack", {cas_n, ack_n}, 32'h1);
        @(negedge clk);
        check(!ack_n, "R6 ack", 32'(ack_n), 0);
        @(negedge clk);

        // R9 R10 refresh with a held request
        rfsh_req = 1'b1;
        @(negedge clk);
        check(rfsh_gnt, "R9 grant", 32'(rfsh_gnt), 1);
        check(ras_n == 2'b11, "R9 rows closed", 32'(ras_n), 32'h3);
        pulse(16'h0205, 1'b0, 1'b0, 1'b1);
        quiet_window("R10 held during refresh", 3);
        rfsh_req = 1'b0;
        @(negedge clk);
        check(!rfsh_gnt, "R9 grant drop", 32'(rfsh_gnt), 0);
        check(ras_n == 2'b10, "R10 ras at release", 32'(ras_n), 32'h2);
        check(ma == row_of(16'h0205), "R10 row", 32'(ma), 32'(row_of(16'h0205)));
        @(negedge clk);
        check(ma == col_of(16'h0205) && ack_n, "R10 column", 32'(ma),
              32'(col_of(16'h0205)));
        @(negedge clk);
        check(!ack_n, "R10 ack two edges later", 32'(ack_n), 0);
        @(negedge clk);

        // R9 page forgotten after refresh: same row reopens
        rfsh_req = 1'b1;
        repeat (2) @(negedge clk);
        rfsh_req = 1'b0;
        @(negedge clk);
        check(ras_n == 2'b11 && !rfsh_gnt, "R9 idle after refresh",
              {rfsh_gnt, ras_n}, 32'h3);
        access(16'h0205, 1'b0, 1'b0, k);
        check(k == 2, "R9 opening after refresh", 32'(k), 2);
        @(negedge clk);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule